// File: doc/BRIEF.md
# Quadrature Encoder Counter with Configuration Lock

This block is a register-mapped position counter for an incremental encoder. Two phase inputs are resynchronised and then compared with their previous sampled state. Every legal change of either phase is one quadrature event, so the block counts four events per encoder line. The phase order gives the direction. A power-of-two prescaler can thin the events before they reach the counter. The counter moves between a programmable lower bound and a programmable upper bound, and it wraps at each of them.

Software reaches the block over a simple word-addressed bus. Register writes take effect at the clock edge, and reads are combinational. A lock flag protects the configuration registers once the block has been set up. A write to the count register never stores the written data. It returns the counter to the lower-bound value. An accepted prescaler change does the same, because the count has no useful meaning after the division ratio changes.

Top module: `qc_top`

Register map (word address: content):
- 0: count. A read returns the live value. A write of any data reloads the lower bound.
- 1: lower bound, bits [15:0], reset 0x0000.
- 2: upper bound, bits [15:0], reset 0xFFFF.
- 3: prescaler code in bits [2:0], reset 0.
- 4: mode. Bit 0 is module enable. Writing 1 to bit 2 releases the lock, and bit 2 always reads 0.
- 5: decoder control. Bit 0 is quadrature enable.
- 6: lock. Bit 0 is the lock flag. Writing 1 to bit 0 sets the flag.
- 7: reads 0.

## Requirements
- R1: After reset, address 0 reads 0x0000, address 1 reads 0x0000, address 2 reads 0xFFFF, and addresses 3, 4, 5 and 6 read 0.
- R2: While counting is active with prescaler code 0, each legal phase change with A leading B (AB sequence 00, 10, 11, 01, 00) adds one to the count.
- R3: While counting is active with prescaler code 0, each legal phase change in the reverse order subtracts one from the count.
- R4: A sample in which both phases change together leaves the count unchanged and does not advance the prescaler.
- R5: An up event at the upper bound loads the lower bound. A down event at the lower bound loads the upper bound.
- R6: With prescaler code n, the count moves once for every 2^n qualified events. The 2^n-th event of a group sets the direction of that move.
- R7: A write of any data to address 0 loads the lower bound into the count and clears the prescaler phase. This write is accepted even while the lock flag is set.
- R8: An accepted write to address 3 stores the new prescaler code, loads the lower bound into the count and clears the prescaler phase.
- R9: While the lock flag is 1, writes to addresses 1, 2, 3 and 5 are ignored, and so are writes to mode bit 0.
- R10: Writing 1 to bit 0 of address 6 sets the lock flag. Writing 1 to mode bit 2 clears it.
- R11: While module enable is 0, writes to the bound registers (addresses 1 and 2) are ignored.
- R12: The count responds to phase events only while both module enable and quadrature enable are 1.
- R13: Reads have no side effects. Address 0 returns the current count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| busAddr | input | 3 | Word address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data |

## Verification
On every cycle, the assertions check the counter step itself. They confirm that each prescaled tick moves the count by exactly one or wraps it at a bound. They also confirm that reloads take the lower bound, that the count holds when there is no tick, that no tick appears while counting is disabled, and that a locked prescaler write changes nothing. Several behaviours can only be shown by the bench scenarios, because they depend on bus traffic and phase sequences spread over many cycles. These are the x4 decoding of whole phase sequences, the rejection of simultaneous phase changes, the group size for each prescaler code, and the lock and enable sequences. The bench checks them against its own register and counter model.

// File: rtl/qc_pkg.sv
package qc_pkg;
  localparam int CNT_W   = 16;
  localparam int PRESC_W = 3;
  localparam int DIV_W   = (1 << PRESC_W) - 1;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOW   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HIGH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRESC = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_QCTL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_LOCK  = 3'd6;

  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_REL_BIT = 2;

  typedef struct packed {
    logic [CNT_W-1:0]   lowVal;
    logic [CNT_W-1:0]   highVal;
    logic [PRESC_W-1:0] presc;
    logic               modEn;
    logic               quadEn;
  } cfg_t;

  typedef struct packed {
    logic cntReload;
  } strobe_t;
endpackage

// File: rtl/qc_ctrl.sv
module qc_ctrl
  import qc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [CNT_W-1:0]  busWrData,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  busRdData,
  output cfg_t              cfg,
  output strobe_t           strb,
  output logic              lockFlag
);
  logic boundWrOk;
  assign boundWrOk = !lockFlag && cfg.modEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.lowVal  <= '0;
      cfg.highVal <= '1;
      cfg.presc   <= '0;
      cfg.modEn   <= 1'b0;
      cfg.quadEn  <= 1'b0;
      lockFlag    <= 1'b0;
    end else if (busWr) begin
      case (busAddr)
        A_LOW:   if (boundWrOk) cfg.lowVal  <= busWrData;
        A_HIGH:  if (boundWrOk) cfg.highVal <= busWrData;
        A_PRESC: if (!lockFlag) cfg.presc   <= busWrData[PRESC_W-1:0];
        A_MODE: begin
          if (lockFlag) begin
            if (busWrData[MODE_REL_BIT]) lockFlag <= 1'b0;
          end else begin
            cfg.modEn <= busWrData[MODE_EN_BIT];
          end
        end
        A_QCTL:  if (!lockFlag) cfg.quadEn <= busWrData[0];
        A_LOCK:  if (busWrData[0]) lockFlag <= 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.cntReload = busWr && ((busAddr == A_COUNT) ||
                               (busAddr == A_PRESC && !lockFlag));
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_COUNT: busRdData = count;
      A_LOW:   busRdData = cfg.lowVal;
      A_HIGH:  busRdData = cfg.highVal;
      A_PRESC: busRdData[PRESC_W-1:0] = cfg.presc;
      A_MODE:  busRdData[MODE_EN_BIT] = cfg.modEn;
      A_QCTL:  busRdData[0] = cfg.quadEn;
      A_LOCK:  busRdData[0] = lockFlag;
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/qc_datapath.sv
module qc_datapath
  import qc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  cfg_t             cfg,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] count,
  output logic             tickUp,
  output logic             tickDn
);
  logic [SYNC_STAGES-1:0] aPipe, bPipe;
  logic [1:0] curAB, prevAB;
  logic evUp, evDn, runEn, divHit;
  logic [DIV_W-1:0] divCnt, divLimit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          aPipe <= '0;
          bPipe <= '0;
        end else begin
          aPipe <= phaseA;
          bPipe <= phaseB;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          aPipe <= '0;
          bPipe <= '0;
        end else begin
          aPipe <= {aPipe[SYNC_STAGES-2:0], phaseA};
          bPipe <= {bPipe[SYNC_STAGES-2:0], phaseB};
        end
      end
    end
  endgenerate

  assign curAB = {aPipe[SYNC_STAGES-1], bPipe[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAB <= 2'b00;
    else       prevAB <= curAB;
  end

  always_comb begin
    evUp = 1'b0;
    evDn = 1'b0;
    case ({prevAB, curAB})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: evUp = 1'b1;
      4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: evDn = 1'b1;
      default: ;
    endcase
  end

  assign runEn    = cfg.modEn && cfg.quadEn;
  assign divLimit = (DIV_W'(1) << cfg.presc) - DIV_W'(1);
  assign divHit   = runEn && (evUp || evDn) && (divCnt == divLimit);
  assign tickUp   = divHit && evUp;
  assign tickDn   = divHit && evDn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.cntReload || divHit) begin
      divCnt <= '0;
    end else if (runEn && (evUp || evDn)) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.cntReload) begin
      count <= cfg.lowVal;
    end else if (tickUp) begin
      count <= (count == cfg.highVal) ? cfg.lowVal : count + CNT_W'(1);
    end else if (tickDn) begin
      count <= (count == cfg.lowVal) ? cfg.highVal : count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/qc_top.sv
module qc_top
  import qc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData
);
  cfg_t             cfg;
  strobe_t          strb;
  logic             lockFlag;
  logic [CNT_W-1:0] count;
  logic             tickUp, tickDn;

  qc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .count(count), .busRdData(busRdData),
    .cfg(cfg), .strb(strb), .lockFlag(lockFlag)
  );

  qc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .cfg(cfg), .strb(strb), .count(count), .tickUp(tickUp), .tickDn(tickDn)
  );
endmodule

// File: rtl/qc_checker.sv
module qc_checker
  import qc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   lowVal,
  input logic [CNT_W-1:0]   highVal,
  input logic [PRESC_W-1:0] presc,
  input logic               modEn,
  input logic               quadEn,
  input logic               lockFlag,
  input logic               reload,
  input logic               tickUp,
  input logic               tickDn
);
  p_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> count == $past(lowVal));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tickUp && !reload && count != highVal) |=> count == $past(count) + CNT_W'(1));

  p_step_dn_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tickDn && !reload && count != lowVal) |=> count == $past(count) - CNT_W'(1));

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickUp && !reload && count == highVal) |=> count == $past(lowVal));

  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickDn && !reload && count == lowVal) |=> count == $past(highVal));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!tickUp && !tickDn && !reload) |=> $stable(count));

  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tickUp, tickDn}));

  p_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(modEn && quadEn) |-> !(tickUp || tickDn));

  p_lock_presc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && busWr && busAddr == A_PRESC) |=> $stable(presc));
endmodule

bind qc_top qc_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .count(count),
  .lowVal(cfg.lowVal), .highVal(cfg.highVal), .presc(cfg.presc),
  .modEn(cfg.modEn), .quadEn(cfg.quadEn), .lockFlag(lockFlag),
  .reload(strb.cntReload), .tickUp(tickUp), .tickDn(tickDn)
);

// File: tb/tb_qc_top.sv
module tb_qc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;

  int checks = 0, errors = 0;
  bit done = 0;
  int mCnt = 0, mLow = 0, mHigh = 16'hFFFF, mPres = 0, mDiv = 0;
  bit mModEn = 0, mQuadEn = 0, mLock = 0;

  always #4 clk = ~clk;

  qc_top dut (.clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
              .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
              .busRdData(busRdData));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    busAddr = 3'(a);
    busWr = 1'b0;
    #1 d = int'(busRdData);
  endtask

  task automatic wr(input int a, input int d);
    case (a)
      0: begin mCnt = mLow; mDiv = 0; end
      1: if (!mLock && mModEn) mLow = d & 16'hFFFF;
      2: if (!mLock && mModEn) mHigh = d & 16'hFFFF;
      3: if (!mLock) begin mPres = d & 7; mCnt = mLow; mDiv = 0; end
      4: if (mLock) begin if (d & 4) mLock = 0; end else mModEn = d[0];
      5: if (!mLock) mQuadEn = d[0];
      6: if (d & 1) mLock = 1;
      default: ;
    endcase
    @(negedge clk);
    busAddr = 3'(a);
    busWrData = 16'(d);
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  function automatic int nextCnt(input int c, input bit up);
    if (up) return (c == mHigh) ? mLow : ((c + 1) & 16'hFFFF);
    return (c == mLow) ? mHigh : ((c - 1) & 16'hFFFF);
  endfunction

  // kind: 0 up, 1 down, 2 both phases change (invalid)
  task automatic step(input int kind);
    logic [1:0] s, n;
    s = {phaseA, phaseB};
    case (kind)
      0: n = (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b11 : (s == 2'b11) ? 2'b01 : 2'b00;
      1: n = (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b11 : (s == 2'b11) ? 2'b10 : 2'b00;
      default: n = ~s;
    endcase
    if (kind < 2 && mModEn && mQuadEn) begin
      if (mDiv == (1 << mPres) - 1) begin
        mDiv = 0;
        mCnt = nextCnt(mCnt, kind == 0);
      end else mDiv++;
    end
    @(negedge clk);
    phaseA = n[1];
    phaseB = n[0];
    repeat (4) @(negedge clk);
  endtask

  task automatic stepChk(input int kind, input string req);
    int d;
    step(kind);
    rd(0, d);
    check(req, d, mCnt);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d, seed, k;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(0, d); check("R1 count", d, 0);
    rd(1, d); check("R1 low", d, 0);
    rd(2, d); check("R1 high", d, 16'hFFFF);
    rd(3, d); check("R1 presc", d, 0);
    rd(4, d); check("R1 mode", d, 0);
    rd(5, d); check("R1 qctl", d, 0);
    rd(6, d); check("R1 lock", d, 0);

    // R12 no counting while disabled
    stepChk(0, "R12 disabled");
    // R11 bound write ignored while module enable is 0
    wr(1, 16'h0055);
    rd(1, d); check("R11 low ignored", d, 0);

    wr(4, 1);
    wr(5, 1);
    for (int i = 0; i < 10; i++) stepChk(0, "R2 up");
    for (int i = 0; i < 14; i++) stepChk(1, "R3 down");
    stepChk(2, "R4 invalid");
    stepChk(2, "R4 invalid back");

    // R5 wrap with bounds 10..20
    wr(1, 10);
    wr(2, 20);
    rd(1, d); check("R11 low accepted", d, 10);
    wr(0, 16'h1234);
    rd(0, d); check("R7 reload", d, 10);
    for (int i = 0; i < 13; i++) stepChk(0, "R5 wrap up");
    for (int i = 0; i < 16; i++) stepChk(1, "R5 wrap down");

    // R8 and R6 prescaler
    step(0);
    wr(3, 2);
    rd(0, d); check("R8 presc reload", d, 10);
    rd(3, d); check("R8 presc stored", d, 2);
    for (int i = 0; i < 9; i++) stepChk(0, "R6 div4");
    step(0); step(0);
    wr(0, 16'hBEEF);
    rd(0, d); check("R7 reload any data", d, 10);
    for (int i = 0; i < 4; i++) stepChk(1, "R6 div clear R7");
    wr(3, 0);

    // R13 reads have no side effects
    for (int a = 0; a < 8; a++) rd(a, d);
    rd(0, d); check("R13 read no effect", d, mCnt);
    stepChk(0, "R13 live count");

    // R10 and R9 lock
    wr(6, 1);
    rd(6, d); check("R10 lock set", d, 1);
    wr(3, 5); rd(3, d); check("R9 presc locked", d, 0);
    wr(1, 3); rd(1, d); check("R9 low locked", d, 10);
    wr(2, 99); rd(2, d); check("R9 high locked", d, 20);
    wr(5, 0); rd(5, d); check("R9 qctl locked", d, 1);
    wr(4, 0); rd(4, d); check("R9 mode locked", d, 1);
    stepChk(0, "R9 still counting");
    wr(0, 0); rd(0, d); check("R7 reload while locked", d, 10);
    wr(4, 4);
    rd(6, d); check("R10 lock released", d, 0);
    rd(4, d); check("R10 mode kept", d, 1);

    // R12 quad enable off
    wr(5, 0);
    stepChk(0, "R12 quad off");
    wr(5, 1);

    // random mix
    wr(1, 100);
    wr(2, 140);
    wr(0, 0);
    for (int i = 0; i < 400; i++) begin
      k = $urandom_range(0, 19);
      if (k == 0) begin
        wr(0, $urandom_range(0, 65535));
        rd(0, d); check("R7 random reload", d, mCnt);
      end else if (k == 1) begin
        wr(3, $urandom_range(0, 3));
        rd(0, d); check("R8 random presc", d, mCnt);
      end else if (k == 2) begin
        stepChk(2, "R4 random invalid");
      end else if (k < 11) begin
        stepChk(0, "R2 R6 random up");
      end else begin
        stepChk(1, "R3 R6 random down");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule